// File: doc/BRIEF.md
# Dual-Parity Stripe Engine

This block computes two parity streams over a stripe of equal-length data buffers. The first stream (P) is a plain byte-wise XOR of the selected buffers. The second stream (Q) multiplies every byte of each selected buffer by a per-buffer coefficient in GF(2^8) and then XORs the products. The low eight bits of the field polynomial come from a configuration input, and the x^8 term is implied.

A job starts with one control beat, which gives the output enables, the cross-XOR and compare options, the buffer count and the byte length. One descriptor beat follows for each buffer, carrying its P select, Q select and Q coefficient. Data then arrives as 64-bit words in column order: for each 8-byte offset there is one word from every buffer, in buffer order. For each finished column the block emits a 64-bit P word and a 64-bit Q word. A pipe in compare mode emits no words. Instead it reports the byte index of the first non-zero byte of its stream. A single-cycle `done` ends every job. A rejected job raises `illegal` with that `done` and processes no data.

Top module: `parity_stripe_engine`

## Requirements
- R1: One cycle after the edge that accepts the last word of a column, `p_valid` is high (if P is enabled and not in compare mode). `p_data` then holds the XOR of that column's words from every buffer whose P select is set.
- R2: `q_data` byte k is the XOR, over Q-selected buffers, of byte k (bits 8k+7..8k) of the word times that buffer's coefficient. The product is taken in GF(2^8) modulo x^8 plus `gf_poly`. A coefficient of 1 makes Q equal P over the same buffers. `q_valid` follows the R1 timing.
- R3: With the Q cross option set, the Q output is the Q result XOR the P result. With the P cross option set, the P output is the P result XOR the Q result.
- R4: A pipe in compare mode never raises its valid. When `done` rises, its position output holds 8*column + k for the first non-zero byte k of its raw result stream. If no byte is non-zero, its none flag is high and the position is all ones.
- R5: `done` is high for exactly one cycle, one cycle after the edge that accepts the job's final data word. It coincides with the last column's outputs.
- R6: A control beat is rejected in these cases: the buffer count is 0 or above MAX_BUF; the length is zero or not a multiple of 8; no output is enabled; either cross option is set without both outputs; or compare mode is set with that pipe's cross option or with that output disabled. A rejected beat gives `done` and `illegal` one cycle later, and no descriptors are taken.
- R7: The descriptor set is rejected in these cases: a P select is set with P disabled; a Q select is set with Q disabled; a Q-selected coefficient is zero; an unselected coefficient is non-zero; or an enabled output has no selecting buffer. A rejected set gives `done` and `illegal` one cycle after the last descriptor, with no data phase and no P/Q valid.
- R8: Data beats outside a data phase produce no output. Control and descriptor beats during a data phase are ignored.
- R9: After reset, `p_valid`, `q_valid`, `done` and `illegal` are low, and `p_none` and `q_none` are high.
- R10: `data_valid` may drop between words. Results are unaffected and are timed from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gf_poly | input | 8 | Field polynomial low bits (x^8 implied) |
| ctl_valid | input | 1 | Control beat strobe |
| ctl_pout | input | 1 | Enable P output |
| ctl_qout | input | 1 | Enable Q output |
| ctl_pxor | input | 1 | P output XOR Q result |
| ctl_qxor | input | 1 | Q output XOR P result |
| ctl_pcmp | input | 1 | P pipe compare mode |
| ctl_qcmp | input | 1 | Q pipe compare mode |
| ctl_nbuf | input | BUF_W (6) | Buffer count |
| ctl_len | input | LEN_W (16) | Bytes per buffer |
| desc_valid | input | 1 | Descriptor beat strobe |
| desc_pen | input | 1 | Buffer joins P |
| desc_qen | input | 1 | Buffer joins Q |
| desc_mult | input | 8 | Buffer Q coefficient |
| data_valid | input | 1 | Data word strobe |
| data_in | input | DATA_W (64) | Data word |
| p_valid | output | 1 | P word valid |
| p_data | output | DATA_W (64) | P word |
| q_valid | output | 1 | Q word valid |
| q_data | output | DATA_W (64) | Q word |
| done | output | 1 | Job finished pulse |
| illegal | output | 1 | Job rejected (with done) |
| p_none | output | 1 | P compare found no non-zero byte |
| p_pos | output | LEN_W (16) | P compare position |
| q_none | output | 1 | Q compare found no non-zero byte |
| q_pos | output | LEN_W (16) | Q compare position |

## Verification
Every result is due one cycle after the clock edge that accepts the beat causing it. Column words and the final `done` follow the last word of a column. A rejection follows the control beat or the last descriptor. When the driver presents such a beat, it records the bench cycle number and pushes the expected item, tagged with that number plus one, into a scoreboard queue. A monitor samples on the falling edge whenever any valid or `done` is high, pops the queue, and checks both the values and that the current cycle equals the tagged one. Any output with an empty queue therefore counts as a failure, and this covers the ignored-beat cases.

// File: rtl/pse_pkg.sv
package pse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DESC = 2'd1,
    ST_DATA = 2'd2
  } pse_state_e;

  typedef struct packed {
    logic pout;
    logic qout;
    logic pxor;
    logic qxor;
    logic pcmp;
    logic qcmp;
  } pse_mode_t;

  localparam int GF_W = 8;
endpackage

// File: rtl/pse_gf_byte_mul.sv
// GF(2^8) product, shift-and-reduce over eight steps.
module pse_gf_byte_mul (
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [7:0] poly,
  output logic [7:0] y
);
  logic [7:0] sh;

  always_comb begin
    y  = '0;
    sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) y = y ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? poly : 8'h00);
    end
  end
endmodule

// File: rtl/pse_gf_word_mul.sv
module pse_gf_word_mul #(
  parameter int LANES = 8
) (
  input  logic [LANES*8-1:0] word,
  input  logic [7:0]         mult,
  input  logic [7:0]         poly,
  output logic [LANES*8-1:0] prod
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pse_gf_byte_mul u_mul (
      .a    (word[g*8 +: 8]),
      .b    (mult),
      .poly (poly),
      .y    (prod[g*8 +: 8])
    );
  end
endmodule

// File: rtl/pse_nz_find.sv
// Lowest-index non-zero byte of a word.
module pse_nz_find #(
  parameter int LANES = 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*8-1:0] word,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (word[i*8 +: 8] != 8'h00) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pse_cmd_check.sv
module pse_cmd_check
  import pse_pkg::*;
#(
  parameter int MAX_BUF = 32,
  parameter int BUF_W   = 6,
  parameter int LEN_W   = 16,
  parameter int LANE_W  = 3
) (
  input  pse_mode_t        ctl_mode,
  input  logic [BUF_W-1:0] ctl_nbuf,
  input  logic [LEN_W-1:0] ctl_len,
  input  logic             run_pout,
  input  logic             run_qout,
  input  logic             d_pen,
  input  logic             d_qen,
  input  logic [7:0]       d_mult,
  output logic             ctl_bad,
  output logic             desc_bad
);
  logic cnt_bad, len_bad, out_bad, xor_bad, cmp_bad;

  always_comb begin
    cnt_bad = (ctl_nbuf == '0) || (int'(ctl_nbuf) > MAX_BUF);
    len_bad = (ctl_len == '0) || (ctl_len[LANE_W-1:0] != '0);
    out_bad = !(ctl_mode.pout || ctl_mode.qout);
    xor_bad = (ctl_mode.pxor || ctl_mode.qxor) && !(ctl_mode.pout && ctl_mode.qout);
    cmp_bad = (ctl_mode.pcmp && (ctl_mode.pxor || !ctl_mode.pout)) ||
              (ctl_mode.qcmp && (ctl_mode.qxor || !ctl_mode.qout));
    ctl_bad = cnt_bad || len_bad || out_bad || xor_bad || cmp_bad;
    desc_bad = (d_pen && !run_pout) || (d_qen && !run_qout) ||
               (d_qen && (d_mult == 8'h00)) || (!d_qen && (d_mult != 8'h00));
  end
endmodule

// File: rtl/parity_stripe_engine.sv
module parity_stripe_engine
  import pse_pkg::*;
#(
  parameter int MAX_BUF = 32,
  parameter int LEN_W   = 16,
  parameter int DATA_W  = 64,
  localparam int BUF_W  = $clog2(MAX_BUF + 1),
  localparam int IDX_W  = (MAX_BUF > 1) ? $clog2(MAX_BUF) : 1,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        gf_poly,
  input  logic              ctl_valid,
  input  logic              ctl_pout,
  input  logic              ctl_qout,
  input  logic              ctl_pxor,
  input  logic              ctl_qxor,
  input  logic              ctl_pcmp,
  input  logic              ctl_qcmp,
  input  logic [BUF_W-1:0]  ctl_nbuf,
  input  logic [LEN_W-1:0]  ctl_len,
  input  logic              desc_valid,
  input  logic              desc_pen,
  input  logic              desc_qen,
  input  logic [7:0]        desc_mult,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  output logic              p_valid,
  output logic [DATA_W-1:0] p_data,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              done,
  output logic              illegal,
  output logic              p_none,
  output logic [LEN_W-1:0]  p_pos,
  output logic              q_none,
  output logic [LEN_W-1:0]  q_pos
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  pse_state_e       state_q, state_d;
  pse_mode_t        mode_q, mode_d, ctl_mode;
  logic [BUF_W-1:0] nbuf_q, nbuf_d, buf_q, buf_d;
  logic [LEN_W-1:0] ncol_q, ncol_d, col_q, col_d;
  logic             any_pen_q, any_pen_d, any_qen_q, any_qen_d, dbad_q, dbad_d;
  logic             p_seen_q, p_seen_d, q_seen_q, q_seen_d;
  logic [LEN_W-1:0] p_pos_q, p_pos_d, q_pos_q, q_pos_d;
  logic             pv_d, qv_d, done_d, ill_d;
  logic [DATA_W-1:0] p_acc_q, q_acc_q, p_term, q_prod, q_term, p_sum, q_sum;
  logic [DATA_W-1:0] p_out, q_out;
  logic              pen_q [MAX_BUF];
  logic              qen_q [MAX_BUF];
  logic [7:0]        mult_q [MAX_BUF];
  logic [IDX_W-1:0]  bidx;
  logic              ctl_bad, desc_bad, desc_fail, last_buf, col_end;
  logic              p_found, q_found;
  logic [LANE_W-1:0] p_idx, q_idx;

  assign ctl_mode = '{pout: ctl_pout, qout: ctl_qout, pxor: ctl_pxor,
                      qxor: ctl_qxor, pcmp: ctl_pcmp, qcmp: ctl_qcmp};
  assign bidx     = buf_q[IDX_W-1:0];
  assign last_buf = (buf_q == nbuf_q - BUF_W'(1));
  assign col_end  = (state_q == ST_DATA) && data_valid && last_buf;

  pse_cmd_check #(.MAX_BUF(MAX_BUF), .BUF_W(BUF_W), .LEN_W(LEN_W), .LANE_W(LANE_W)) u_check (
    .ctl_mode (ctl_mode),
    .ctl_nbuf (ctl_nbuf),
    .ctl_len  (ctl_len),
    .run_pout (mode_q.pout),
    .run_qout (mode_q.qout),
    .d_pen    (desc_pen),
    .d_qen    (desc_qen),
    .d_mult   (desc_mult),
    .ctl_bad  (ctl_bad),
    .desc_bad (desc_bad)
  );

  assign desc_fail = dbad_q || desc_bad ||
                     (mode_q.pout && !(any_pen_q || desc_pen)) ||
                     (mode_q.qout && !(any_qen_q || desc_qen));

  // datapath: per-word accumulation of both pipes
  pse_gf_word_mul #(.LANES(LANES)) u_qmul (
    .word (data_in),
    .mult (mult_q[bidx]),
    .poly (gf_poly),
    .prod (q_prod)
  );

  assign p_term = pen_q[bidx] ? data_in : '0;
  assign q_term = qen_q[bidx] ? q_prod  : '0;
  assign p_sum  = ((buf_q == '0) ? '0 : p_acc_q) ^ p_term;
  assign q_sum  = ((buf_q == '0) ? '0 : q_acc_q) ^ q_term;
  assign p_out  = mode_q.pxor ? (p_sum ^ q_sum) : p_sum;
  assign q_out  = mode_q.qxor ? (q_sum ^ p_sum) : q_sum;

  pse_nz_find #(.LANES(LANES)) u_pnz (.word(p_sum), .found(p_found), .idx(p_idx));
  pse_nz_find #(.LANES(LANES)) u_qnz (.word(q_sum), .found(q_found), .idx(q_idx));

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    nbuf_d    = nbuf_q;
    ncol_d    = ncol_q;
    buf_d     = buf_q;
    col_d     = col_q;
    any_pen_d = any_pen_q;
    any_qen_d = any_qen_q;
    dbad_d    = dbad_q;
    p_seen_d  = p_seen_q;
    q_seen_d  = q_seen_q;
    p_pos_d   = p_pos_q;
    q_pos_d   = q_pos_q;
    pv_d      = 1'b0;
    qv_d      = 1'b0;
    done_d    = 1'b0;
    ill_d     = 1'b0;
    case (state_q)
      ST_IDLE: if (ctl_valid) begin
        if (ctl_bad) begin
          ill_d  = 1'b1;
          done_d = 1'b1;
        end else begin
          state_d   = ST_DESC;
          mode_d    = ctl_mode;
          nbuf_d    = ctl_nbuf;
          ncol_d    = ctl_len >> LANE_W;
          buf_d     = '0;
          any_pen_d = 1'b0;
          any_qen_d = 1'b0;
          dbad_d    = 1'b0;
          p_seen_d  = 1'b0;
          q_seen_d  = 1'b0;
          p_pos_d   = '1;
          q_pos_d   = '1;
        end
      end
      ST_DESC: if (desc_valid) begin
        any_pen_d = any_pen_q || desc_pen;
        any_qen_d = any_qen_q || desc_qen;
        dbad_d    = dbad_q || desc_bad;
        if (last_buf) begin
          buf_d = '0;
          col_d = '0;
          if (desc_fail) begin
            ill_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DATA;
          end
        end else begin
          buf_d = buf_q + BUF_W'(1);
        end
      end
      ST_DATA: if (data_valid) begin
        if (last_buf) begin
          buf_d = '0;
          pv_d  = mode_q.pout && !mode_q.pcmp;
          qv_d  = mode_q.qout && !mode_q.qcmp;
          if (!p_seen_q && p_found) begin
            p_seen_d = 1'b1;
            p_pos_d  = {col_q[LEN_W-LANE_W-1:0], p_idx};
          end
          if (!q_seen_q && q_found) begin
            q_seen_d = 1'b1;
            q_pos_d  = {col_q[LEN_W-LANE_W-1:0], q_idx};
          end
          if (col_q == ncol_q - LEN_W'(1)) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            col_d = col_q + LEN_W'(1);
          end
        end else begin
          buf_d = buf_q + BUF_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= ST_IDLE;
      mode_q    <= '0;
      nbuf_q    <= '0;
      ncol_q    <= '0;
      buf_q     <= '0;
      col_q     <= '0;
      any_pen_q <= 1'b0;
      any_qen_q <= 1'b0;
      dbad_q    <= 1'b0;
      p_seen_q  <= 1'b0;
      q_seen_q  <= 1'b0;
      p_pos_q   <= '1;
      q_pos_q   <= '1;
      p_valid   <= 1'b0;
      q_valid   <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      state_q   <= state_d;
      mode_q    <= mode_d;
      nbuf_q    <= nbuf_d;
      ncol_q    <= ncol_d;
      buf_q     <= buf_d;
      col_q     <= col_d;
      any_pen_q <= any_pen_d;
      any_qen_q <= any_qen_d;
      dbad_q    <= dbad_d;
      p_seen_q  <= p_seen_d;
      q_seen_q  <= q_seen_d;
      p_pos_q   <= p_pos_d;
      q_pos_q   <= q_pos_d;
      p_valid   <= pv_d;
      q_valid   <= qv_d;
      done      <= done_d;
      illegal   <= ill_d;
    end
  end

  // storage without reset, written under explicit enables
  always_ff @(posedge clk) begin
    if ((state_q == ST_DESC) && desc_valid) begin
      pen_q[bidx]  <= desc_pen;
      qen_q[bidx]  <= desc_qen;
      mult_q[bidx] <= desc_mult;
    end
    if ((state_q == ST_DATA) && data_valid) begin
      p_acc_q <= p_sum;
      q_acc_q <= q_sum;
    end
    if (col_end) begin
      p_data <= p_out;
      q_data <= q_out;
    end
  end

  assign p_none = !p_seen_q;
  assign q_none = !q_seen_q;
  assign p_pos  = p_pos_q;
  assign q_pos  = q_pos_q;

  // observation points for the bound checker
  logic             is_idle, run_pcmp, run_qcmp;
  logic [LEN_W-1:0] run_len;
  assign is_idle  = (state_q == ST_IDLE);
  assign run_pcmp = mode_q.pcmp;
  assign run_qcmp = mode_q.qcmp;
  assign run_len  = ncol_q << LANE_W;
endmodule

// File: rtl/pse_checker.sv
module pse_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             is_idle,
  input logic             run_pcmp,
  input logic             run_qcmp,
  input logic [LEN_W-1:0] run_len,
  input logic             p_valid,
  input logic             q_valid,
  input logic             done,
  input logic             illegal,
  input logic             p_none,
  input logic [LEN_W-1:0] p_pos,
  input logic             q_none,
  input logic [LEN_W-1:0] q_pos
);
  // R6: a rejection is always reported together with done
  assert_illegal_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R7: a rejected job emits no parity words
  assert_illegal_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!p_valid && !q_valid));

  assert_pcmp_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_pcmp |-> !p_valid);

  assert_qcmp_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_qcmp |-> !q_valid);

  assert_ppos_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && run_pcmp && !p_none) |-> (p_pos < run_len));

  assert_qnone_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && run_qcmp && q_none) |-> (&q_pos));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && $past(is_idle)) |-> (!p_valid && !q_valid));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |=> (!done || illegal));
endmodule

bind parity_stripe_engine pse_checker #(.LEN_W(LEN_W)) u_pse_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .is_idle  (is_idle),
  .run_pcmp (run_pcmp),
  .run_qcmp (run_qcmp),
  .run_len  (run_len),
  .p_valid  (p_valid),
  .q_valid  (q_valid),
  .done     (done),
  .illegal  (illegal),
  .p_none   (p_none),
  .p_pos    (p_pos),
  .q_none   (q_none),
  .q_pos    (q_pos)
);

// File: tb/test_parity_stripe_engine.sv
module test_parity_stripe_engine;
  logic        clk;
  logic        rst_n;
  logic [7:0]  gf_poly;
  logic        ctl_valid, ctl_pout, ctl_qout, ctl_pxor, ctl_qxor, ctl_pcmp, ctl_qcmp;
  logic [5:0]  ctl_nbuf;
  logic [15:0] ctl_len;
  logic        desc_valid, desc_pen, desc_qen;
  logic [7:0]  desc_mult;
  logic        data_valid;
  logic [63:0] data_in;
  logic        p_valid, q_valid, done, illegal, p_none, q_none;
  logic [63:0] p_data, q_data;
  logic [15:0] p_pos, q_pos;

  parity_stripe_engine i_parity_stripe_engine (
    .clk(clk), .rst_n(rst_n), .gf_poly(gf_poly),
    .ctl_valid(ctl_valid), .ctl_pout(ctl_pout), .ctl_qout(ctl_qout),
    .ctl_pxor(ctl_pxor), .ctl_qxor(ctl_qxor), .ctl_pcmp(ctl_pcmp), .ctl_qcmp(ctl_qcmp),
    .ctl_nbuf(ctl_nbuf), .ctl_len(ctl_len),
    .desc_valid(desc_valid), .desc_pen(desc_pen), .desc_qen(desc_qen), .desc_mult(desc_mult),
    .data_valid(data_valid), .data_in(data_in),
    .p_valid(p_valid), .p_data(p_data), .q_valid(q_valid), .q_data(q_data),
    .done(done), .illegal(illegal),
    .p_none(p_none), .p_pos(p_pos), .q_none(q_none), .q_pos(q_pos)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int outs   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          cyc;
    bit          done, ill, pv, qv, chk_p, chk_q, pn, qn;
    logic [63:0] pd, qd;
    logic [15:0] pp, qp;
    string       req;
  } exp_t;
  exp_t sbq[$];

  bit          d_pen  [32];
  bit          d_qen  [32];
  logic [7:0]  d_mult [32];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic exp_t blank(input int c, input string r);
    exp_t e;
    e.cyc = c; e.done = 0; e.ill = 0; e.pv = 0; e.qv = 0; e.chk_p = 0; e.chk_q = 0;
    e.pn = 0; e.qn = 0; e.pd = '0; e.qd = '0; e.pp = '0; e.qp = '0; e.req = r;
    return e;
  endfunction

  // bit-serial reference, most significant coefficient bit first
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] poly);
    logic [7:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? poly : 8'h00);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // scoreboard monitor, sampling on the falling edge
  exp_t me;
  always @(negedge clk) begin
    if (rst_n && (p_valid || q_valid || done)) begin
      outs++;
      if (sbq.size() == 0) begin
        check(1'b0, "R8", "unexpected output", {61'd0, p_valid, q_valid, done}, 64'd0);
      end else begin
        me = sbq.pop_front();
        check(cyc == me.cyc, me.req, "cycle", 64'(cyc), 64'(me.cyc));
        check(done == me.done, me.req, "done", 64'(done), 64'(me.done));
        check(illegal == me.ill, me.req, "illegal", 64'(illegal), 64'(me.ill));
        check(p_valid == me.pv, me.req, "p_valid", 64'(p_valid), 64'(me.pv));
        check(q_valid == me.qv, me.req, "q_valid", 64'(q_valid), 64'(me.qv));
        if (me.pv) check(p_data == me.pd, me.req, "p_data", p_data, me.pd);
        if (me.qv) check(q_data == me.qd, me.req, "q_data", q_data, me.qd);
        if (me.chk_p) begin
          check(p_none == me.pn, me.req, "p_none", 64'(p_none), 64'(me.pn));
          check(p_pos == me.pp, me.req, "p_pos", 64'(p_pos), 64'(me.pp));
        end
        if (me.chk_q) begin
          check(q_none == me.qn, me.req, "q_none", 64'(q_none), 64'(me.qn));
          check(q_pos == me.qp, me.req, "q_pos", 64'(q_pos), 64'(me.qp));
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R5 watchdog: cycle %0d expected below %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic set_all(input int nb, input bit pe, input bit qe, input int mmode);
    for (int b = 0; b < 32; b++) begin
      d_pen[b]  = (b < nb) ? pe : 1'b0;
      d_qen[b]  = (b < nb) ? qe : 1'b0;
      d_mult[b] = 8'h00;
      if (b < nb && qe) d_mult[b] = (mmode == 1) ? 8'h01 : 8'($urandom % 255 + 1);
    end
  endtask

  task automatic run_cmd(input bit po, input bit qo, input bit px, input bit qx,
                         input bit pc, input bit qc, input int nb, input int ln,
                         input int dm, input int nzp, input bit gaps, input bit poke,
                         input string req);
    bit cbad, dbad, anyp, anyq, ps, qs;
    int c_last;
    logic [63:0] w, pacc, qacc, tp;
    logic [15:0] ppos, qpos;
    exp_t e;
    cbad = (nb == 0) || (nb > 32) || (ln == 0) || (ln % 8 != 0) || !(po || qo) ||
           ((px || qx) && !(po && qo)) || (pc && (px || !po)) || (qc && (qx || !qo));
    @(posedge clk); #1;
    ctl_valid = 1; ctl_pout = po; ctl_qout = qo; ctl_pxor = px; ctl_qxor = qx;
    ctl_pcmp = pc; ctl_qcmp = qc; ctl_nbuf = 6'(nb); ctl_len = 16'(ln);
    c_last = cyc;
    @(posedge clk); #1;
    ctl_valid = 0;
    if (cbad) begin
      e = blank(c_last + 1, req); e.done = 1; e.ill = 1;
      sbq.push_back(e);
      return;
    end
    dbad = 0; anyp = 0; anyq = 0;
    for (int b = 0; b < nb; b++) begin
      desc_valid = 1; desc_pen = d_pen[b]; desc_qen = d_qen[b]; desc_mult = d_mult[b];
      dbad = dbad || (d_pen[b] && !po) || (d_qen[b] && !qo) ||
             (d_qen[b] && d_mult[b] == 0) || (!d_qen[b] && d_mult[b] != 0);
      anyp = anyp || d_pen[b];
      anyq = anyq || d_qen[b];
      c_last = cyc;
      @(posedge clk); #1;
    end
    desc_valid = 0;
    if (dbad || (po && !anyp) || (qo && !anyq)) begin
      e = blank(c_last + 1, req); e.done = 1; e.ill = 1;
      sbq.push_back(e);
      return;
    end
    ps = 0; qs = 0; ppos = '1; qpos = '1;
    for (int col = 0; col < ln / 8; col++) begin
      pacc = '0; qacc = '0;
      for (int b = 0; b < nb; b++) begin
        w = (dm == 0) ? {$urandom, $urandom} : 64'd0;
        if (dm == 2 && b == 0 && col == nzp / 8) w[(nzp % 8) * 8 +: 8] = 8'h5A;
        data_valid = 1; data_in = w;
        if (poke && col == 0 && b == 0) begin
          ctl_valid = 1; ctl_nbuf = 6'd0; desc_valid = 1; desc_mult = 8'h00;
        end
        c_last = cyc;
        for (int k = 0; k < 8; k++) tp[k*8 +: 8] = ref_mul(w[k*8 +: 8], d_mult[b], gf_poly);
        if (d_pen[b]) pacc = pacc ^ w;
        if (d_qen[b]) qacc = qacc ^ tp;
        if (b == nb - 1) begin
          for (int k = 0; k < 8; k++) begin
            if (!ps && pacc[k*8 +: 8] != 0) begin ps = 1; ppos = 16'(col * 8 + k); end
            if (!qs && qacc[k*8 +: 8] != 0) begin qs = 1; qpos = 16'(col * 8 + k); end
          end
          e = blank(c_last + 1, req);
          e.pv = po && !pc; e.qv = qo && !qc;
          e.pd = px ? (pacc ^ qacc) : pacc;
          e.qd = qx ? (qacc ^ pacc) : qacc;
          e.done = (col == ln / 8 - 1);
          e.chk_p = e.done && pc; e.pn = !ps; e.pp = ppos;
          e.chk_q = e.done && qc; e.qn = !qs; e.qp = qpos;
          if (e.pv || e.qv || e.done) sbq.push_back(e);
        end
        @(posedge clk); #1;
        data_valid = 0; ctl_valid = 0; desc_valid = 0;
        if (gaps) begin @(posedge clk); #1; end
      end
    end
  endtask

  task automatic drain(input string req);
    repeat (4) @(posedge clk);
    #1;
    check(sbq.size() == 0, req, "pending results", 64'(sbq.size()), 64'd0);
  endtask

  initial begin
    int o0, nb, ln;
    rst_n = 0; gf_poly = 8'h1D;
    ctl_valid = 0; ctl_pout = 0; ctl_qout = 0; ctl_pxor = 0; ctl_qxor = 0;
    ctl_pcmp = 0; ctl_qcmp = 0; ctl_nbuf = '0; ctl_len = '0;
    desc_valid = 0; desc_pen = 0; desc_qen = 0; desc_mult = '0;
    data_valid = 0; data_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(!p_valid && !q_valid, "R9", "valids after reset", {62'd0, p_valid, q_valid}, 64'd0);
    check(!done && !illegal, "R9", "done/illegal after reset", {62'd0, done, illegal}, 64'd0);
    check(p_none && q_none, "R9", "none flags after reset", {62'd0, p_none, q_none}, 64'd3);

    // R1: P only, some buffers excluded
    set_all(3, 1, 0, 0); d_pen[1] = 0;
    run_cmd(1, 0, 0, 0, 0, 0, 3, 24, 0, 0, 0, 0, "R1");
    drain("R1");

    // R2: P and Q with mixed selection
    set_all(5, 1, 1, 2); d_pen[2] = 0; d_qen[4] = 0; d_mult[4] = 0;
    run_cmd(1, 1, 0, 0, 0, 0, 5, 32, 0, 0, 0, 0, "R2");
    // R2: coefficient 1 turns Q into the same XOR as P
    set_all(4, 1, 1, 1);
    run_cmd(1, 1, 0, 0, 0, 0, 4, 16, 0, 0, 0, 0, "R2");
    // R2: random polynomials and coefficients
    for (int i = 0; i < 8; i++) begin
      gf_poly = 8'($urandom);
      nb = 1 + ($urandom % 32);
      ln = 8 * (1 + ($urandom % 4));
      for (int b = 0; b < 32; b++) begin
        d_pen[b] = (b < nb) ? 1'($urandom) : 1'b0;
        d_qen[b] = (b < nb) ? 1'($urandom) : 1'b0;
        d_mult[b] = d_qen[b] ? 8'($urandom % 255 + 1) : 8'h00;
      end
      d_pen[0] = 1; d_qen[nb - 1] = 1; d_mult[nb - 1] = 8'($urandom % 255 + 1);
      run_cmd(1, 1, 0, 0, 0, 0, nb, ln, 0, 0, 0, 0, "R2");
    end
    drain("R2");

    // R3: cross-XOR options
    gf_poly = 8'h2B;
    set_all(6, 1, 1, 2);
    run_cmd(1, 1, 0, 1, 0, 0, 6, 24, 0, 0, 0, 0, "R3");
    run_cmd(1, 1, 1, 0, 0, 0, 6, 24, 0, 0, 0, 0, "R3");
    run_cmd(1, 1, 1, 1, 0, 0, 6, 16, 0, 0, 0, 0, "R3");
    drain("R3");

    // R4: compare mode, one non-zero byte at index 13; R10 with gaps
    set_all(3, 1, 1, 2);
    run_cmd(1, 1, 0, 0, 1, 0, 3, 32, 2, 13, 0, 0, "R4");
    run_cmd(1, 1, 0, 0, 0, 1, 3, 32, 1, 0, 0, 0, "R4");
    run_cmd(1, 1, 0, 0, 1, 1, 3, 40, 2, 37, 1, 0, "R10");
    run_cmd(1, 1, 0, 0, 1, 1, 3, 16, 0, 0, 0, 0, "R4");
    run_cmd(1, 1, 0, 0, 0, 0, 4, 24, 0, 0, 1, 0, "R10");
    drain("R4");

    // R6: control-beat rejections
    set_all(2, 1, 1, 2);
    run_cmd(1, 1, 0, 0, 0, 0, 0, 16, 0, 0, 0, 0, "R6");
    run_cmd(1, 1, 0, 0, 0, 0, 33, 16, 0, 0, 0, 0, "R6");
    run_cmd(1, 1, 0, 0, 0, 0, 2, 12, 0, 0, 0, 0, "R6");
    run_cmd(1, 1, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, "R6");
    run_cmd(0, 0, 0, 0, 0, 0, 2, 16, 0, 0, 0, 0, "R6");
    run_cmd(1, 0, 1, 0, 0, 0, 2, 16, 0, 0, 0, 0, "R6");
    run_cmd(1, 1, 1, 0, 1, 0, 2, 16, 0, 0, 0, 0, "R6");
    run_cmd(1, 0, 0, 0, 0, 1, 2, 16, 0, 0, 0, 0, "R6");
    drain("R6");

    // R7: descriptor rejections
    set_all(3, 1, 0, 0);
    run_cmd(0, 1, 0, 0, 0, 0, 3, 16, 0, 0, 0, 0, "R7");
    set_all(3, 1, 1, 2); d_mult[1] = 8'h00;
    run_cmd(1, 1, 0, 0, 0, 0, 3, 16, 0, 0, 0, 0, "R7");
    set_all(3, 1, 0, 0); d_mult[2] = 8'h07;
    run_cmd(1, 0, 0, 0, 0, 0, 3, 16, 0, 0, 0, 0, "R7");
    set_all(3, 0, 1, 2);
    run_cmd(1, 1, 0, 0, 0, 0, 3, 16, 0, 0, 0, 0, "R7");
    set_all(2, 1, 1, 2);
    run_cmd(1, 1, 0, 0, 0, 0, 2, 16, 0, 0, 0, 0, "R7");
    drain("R7");

    // R8: idle data beats and busy control/descriptor beats are ignored
    o0 = outs;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      data_valid = 1; data_in = {$urandom, $urandom};
    end
    @(posedge clk); #1 data_valid = 0;
    repeat (3) @(posedge clk);
    #1 check(outs == o0, "R8", "outputs from idle data", 64'(outs - o0), 64'd0);
    set_all(3, 1, 1, 2);
    run_cmd(1, 1, 0, 0, 0, 0, 3, 24, 0, 0, 0, 1, "R8");
    drain("R8");

    // R5: done pulse counted against legal jobs on a final run
    o0 = outs;
    run_cmd(1, 1, 0, 0, 0, 0, 3, 8, 0, 0, 0, 0, "R5");
    drain("R5");
    check(outs - o0 == 1, "R5", "output cycles for one-column job", 64'(outs - o0), 64'd1);

    summary();
    $finish;
  end
endmodule